// File: doc/BRIEF.md
# Burst Column Sequencer

This block reproduces the data-path timing of a synchronous burst memory device. A small mode register, loaded from a 12-bit key, sets the burst length, the burst ordering, the read latency and a single-write option. Read and write commands launch a burst that steps through column addresses one per clock. Writes carry a per-byte enable that is active in the same cycle as the column. Reads raise a data-valid flag after the programmed latency, and a per-byte output enable follows the byte mask with a two-cycle delay.

A burst ends when its length runs out. It also ends when a burst stop, a precharge, a mode load or a new read or write arrives. A full-page burst wraps around the whole column space and only stops when it is interrupted. The block has no row decode, no refresh and no storage array; it produces the timing strobes that a memory model or a controller testbench lines up against.

Top module: `burst_colseq`

## Requirements
- R1: While reset is applied, and afterwards until a command arrives, col_o is 0 and rd_valid_o, wr_en_o and oe_o are all zero. The mode after reset is burst length 1, sequential order, read latency 2 and single-write off.
- R2: A mode-set command (cmd_i=1) loads key_i only when every field is legal. Bits [2:0] set the length: 0→1, 1→2, 2→4, 3→8, 7→full page. Bit 3 selects interleaved order when set. Bits [6:4] set the read latency L, either 2 or 3. Bit 9 enables single-write. Bits [8:7] and [11:10] must be 0. Length 7 together with bit 3 set is illegal. A key with any illegal field leaves the mode unchanged.
- R3: Sequential order, for length N up to 8. Beat i of a burst that starts at column S is S with its low log2(N) bits replaced by (S+i) mod N; the upper bits are unchanged. For a command presented in cycle c, beat i appears on col_o in cycle c+1+i.
- R4: Interleaved order gives beat i the column S XOR i, on the same schedule as R3.
- R5: A full-page burst uses column (S+i) mod 256 and runs without end until it is interrupted.
- R6: Each read beat i of a read command (cmd_i=2) presented in cycle c raises rd_valid_o in cycle c+i+L.
- R7: A write command (cmd_i=3) and each later write beat drive wr_en_o in the cycle after mask_i is sampled. Each bit of wr_en_o is the inverse of the mask_i bit for that byte, taken in the same cycle as the command or beat.
- R8: While rd_valid_o is high, each bit of oe_o is the inverse of the mask_i bit for that byte, sampled two cycles earlier. oe_o is zero whenever rd_valid_o is low.
- R9: When a burst stop (cmd_i=4) or a precharge (cmd_i=5) interrupts a read, rd_valid_o is high for exactly L−1 cycles after the interrupting cycle and then stays low.
- R10: When a burst stop or a precharge interrupts a write, wr_en_o is zero from the cycle after the interrupting command onward, whatever mask_i is.
- R11: With single-write on, every write burst has exactly one beat. Read bursts still use the programmed length.
- R12: A read or write command that arrives during a burst ends that burst. The new sequence starts from the new column on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command: 0 none, 1 mode set, 2 read, 3 write, 4 burst stop, 5 precharge, 6–7 none |
| key_i | input | 12 | Mode key, sampled on a mode-set command |
| col_i | input | 8 | Starting column for read or write |
| mask_i | input | 2 | Per-byte mask, high blocks the byte |
| col_o | output | 8 | Column of the current burst beat |
| rd_valid_o | output | 1 | Read data valid, latency applied |
| wr_en_o | output | 2 | Per-byte write enable of the current beat |
| oe_o | output | 2 | Per-byte output enable for read data |

## Verification
The bench sweeps every legal length in both orders at both latencies. Each setting uses three start columns: one aligned, one mid-block and one near the top of the column space. This separates wrap within the burst block from carry into the upper bits, and it separates sequential from interleaved order. The mask follows a rolling pattern that never lines up with the burst, so an error in the delay of the read mask or the write mask shows up. A long full-page run crosses column 255. Further directed sequences cover interrupts after a few beats, restarts mid-burst, illegal keys and single-write. They show whether the interrupt keeps exactly L−1 data words in flight and whether an ignored key leaves the old burst shape intact.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_MODE  = 3'd1;
  localparam logic [2:0] CMD_READ  = 3'd2;
  localparam logic [2:0] CMD_WRITE = 3'd3;
  localparam logic [2:0] CMD_STOP  = 3'd4;
  localparam logic [2:0] CMD_PRE   = 3'd5;

  // smallest read latency the data-valid pipeline supports
  localparam int LAT_MIN   = 2;
  localparam int LEN_LOG_W = 4;

  typedef struct packed {
    logic [LEN_LOG_W-1:0] len_log;   // log2 of burst length when not full page
    logic                 full;      // full-page burst
    logic                 ilv;       // interleaved ordering
    logic [2:0]           lat;       // read latency in clocks
    logic                 single_wr; // writes are one beat long
  } mode_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
#(
  parameter int KEY_W   = 12,
  parameter int LAT_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output mode_t            mode
);
  logic [2:0] len_f;
  logic [2:0] lat_f;
  logic       ilv_f;
  logic       sw_f;
  logic       len_ok;
  logic       lat_ok;
  logic       rsv_ok;

  always_comb begin
    len_f  = key[2:0];
    ilv_f  = key[3];
    lat_f  = key[6:4];
    sw_f   = key[9];
    len_ok = (len_f <= 3'd3) || (len_f == 3'd7 && !ilv_f);
    lat_ok = (int'(lat_f) >= LAT_MIN) && (int'(lat_f) <= LAT_MAX);
    rsv_ok = (key[8:7] == 2'b00) && (key[KEY_W-1:10] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode.len_log   <= '0;
      mode.full      <= 1'b0;
      mode.ilv       <= 1'b0;
      mode.lat       <= 3'(LAT_MIN);
      mode.single_wr <= 1'b0;
    end else if (load && len_ok && lat_ok && rsv_ok) begin
      mode.full      <= (len_f == 3'd7);
      mode.len_log   <= (len_f == 3'd7) ? '0 : LEN_LOG_W'(len_f);
      mode.ilv       <= ilv_f;
      mode.lat       <= lat_f;
      mode.single_wr <= sw_f;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd,
  input  logic [COL_W-1:0]     col_in,
  input  logic [BYTES-1:0]     mask,
  input  logic [LEN_LOG_W-1:0] len_log,
  input  logic                 full_pg,
  input  logic                 ilv,
  input  logic                 single_wr,
  output logic [COL_W-1:0]     col_q,
  output logic                 beat_rd,
  output logic [BYTES-1:0]     wr_q
);
  logic             active;
  logic             is_wr;
  logic             ilv_b;
  logic             full_b;
  logic [COL_W-1:0] start;
  logic [COL_W-1:0] beat_k;
  logic [COL_W-1:0] wrap_m;
  logic [COL_W-1:0] new_m;
  logic [COL_W-1:0] nxt_col;
  logic             is_rw;
  logic             is_kill;
  logic             one_beat_wr;

  always_comb begin
    is_rw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    is_kill     = (cmd == CMD_STOP) || (cmd == CMD_PRE) || (cmd == CMD_MODE);
    one_beat_wr = (cmd == CMD_WRITE) && single_wr;
    if (one_beat_wr)  new_m = '0;
    else if (full_pg) new_m = '1;
    else              new_m = COL_W'((1 << len_log) - 1);
    // interleave flips low bits; sequential adds within the wrap block
    if (ilv_b) nxt_col = start ^ beat_k;
    else       nxt_col = (start & ~wrap_m) | ((start + beat_k) & wrap_m);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      is_wr   <= 1'b0;
      ilv_b   <= 1'b0;
      full_b  <= 1'b0;
      start   <= '0;
      beat_k  <= '0;
      wrap_m  <= '0;
      col_q   <= '0;
      beat_rd <= 1'b0;
      wr_q    <= '0;
    end else if (is_rw) begin
      start   <= col_in;
      beat_k  <= COL_W'(1);
      wrap_m  <= new_m;
      ilv_b   <= ilv;
      full_b  <= full_pg && !one_beat_wr;
      is_wr   <= (cmd == CMD_WRITE);
      active  <= (new_m != '0);
      col_q   <= col_in;
      beat_rd <= (cmd == CMD_READ);
      wr_q    <= (cmd == CMD_WRITE) ? ~mask : '0;
    end else if (is_kill) begin
      active  <= 1'b0;
      beat_rd <= 1'b0;
      wr_q    <= '0;
    end else if (active) begin
      col_q   <= nxt_col;
      beat_k  <= beat_k + 1'b1;
      active  <= full_b || (beat_k != wrap_m);
      beat_rd <= !is_wr;
      wr_q    <= is_wr ? ~mask : '0;
    end else begin
      beat_rd <= 1'b0;
      wr_q    <= '0;
    end
  end
endmodule

// File: rtl/burst_rd_pipe.sv
module burst_rd_pipe
  import burst_pkg::*;
#(
  parameter int LAT_MAX = 3,
  parameter int BYTES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_rd,
  input  logic [2:0]       lat,
  input  logic [BYTES-1:0] mask,
  output logic             rd_valid,
  output logic [BYTES-1:0] oe
);
  // beat_rd already carries one register; the rest of the latency lives here
  localparam int DEPTH = LAT_MAX - LAT_MIN + 1;

  logic [DEPTH-1:0] pipe;
  logic [BYTES-1:0] mask_d1;
  logic [BYTES-1:0] mask_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe    <= '0;
      mask_d1 <= '0;
      mask_d2 <= '0;
    end else begin
      pipe[0] <= beat_rd;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
      mask_d1 <= mask;
      mask_d2 <= mask_d1;
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(lat) == i + LAT_MIN) rd_valid = pipe[i];
    oe = rd_valid ? ~mask_d2 : '0;
  end
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int KEY_W   = 12,
  parameter int BYTES   = 2,
  parameter int LAT_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [BYTES-1:0] mask_i,
  output logic [COL_W-1:0] col_o,
  output logic             rd_valid_o,
  output logic [BYTES-1:0] wr_en_o,
  output logic [BYTES-1:0] oe_o
);
  mode_t mode_q;
  logic  beat_rd;

  burst_mode_reg #(.KEY_W(KEY_W), .LAT_MAX(LAT_MAX)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (cmd_i == CMD_MODE),
    .key  (key_i),
    .mode (mode_q)
  );

  burst_col_gen #(.COL_W(COL_W), .BYTES(BYTES)) u_cols (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_i),
    .col_in    (col_i),
    .mask      (mask_i),
    .len_log   (mode_q.len_log),
    .full_pg   (mode_q.full),
    .ilv       (mode_q.ilv),
    .single_wr (mode_q.single_wr),
    .col_q     (col_o),
    .beat_rd   (beat_rd),
    .wr_q      (wr_en_o)
  );

  burst_rd_pipe #(.LAT_MAX(LAT_MAX), .BYTES(BYTES)) u_rdp (
    .clk      (clk),
    .rst      (rst),
    .beat_rd  (beat_rd),
    .lat      (mode_q.lat),
    .mask     (mask_i),
    .rd_valid (rd_valid_o),
    .oe       (oe_o)
  );
endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk
  import burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BYTES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_i,
  input logic [COL_W-1:0] col_i,
  input logic [BYTES-1:0] mask_i,
  input logic [COL_W-1:0] col_o,
  input logic             rd_valid_o,
  input logic [BYTES-1:0] wr_en_o,
  input logic [BYTES-1:0] oe_o,
  input logic             single_wr
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (col_o == '0 && !rd_valid_o && wr_en_o == '0 && oe_o == '0));

  assert_start_col_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_READ || cmd_i == CMD_WRITE) |=> col_o == $past(col_i));

  assert_write_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_WRITE) |=> wr_en_o == ~$past(mask_i));

  assert_halt_write_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_STOP || cmd_i == CMD_PRE) |=> wr_en_o == '0);

  assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_WRITE && single_wr) ##1 (cmd_i == CMD_NOP) |=> wr_en_o == '0);

  assert_read_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && rd_valid_o) |-> ((oe_o & $past(mask_i, 2)) == '0));
endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W), .BYTES(BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_i      (cmd_i),
  .col_i      (col_i),
  .mask_i     (mask_i),
  .col_o      (col_o),
  .rd_valid_o (rd_valid_o),
  .wr_en_o    (wr_en_o),
  .oe_o       (oe_o),
  .single_wr  (mode_q.single_wr)
);

// File: tb/burst_colseq_bench.sv
module burst_colseq_bench;
  localparam logic [2:0] C_NOP = 3'd0, C_MODE = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_STOP = 3'd4, C_PRE = 3'd5;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cmd;
  logic [11:0] key;
  logic [7:0]  col;
  logic [1:0]  mask;
  logic [7:0]  col_o;
  logic        rd_valid_o;
  logic [1:0]  wr_en_o;
  logic [1:0]  oe_o;

  always #2 clk = ~clk;

  burst_colseq u_burst_colseq (
    .clk(clk), .rst(rst), .cmd_i(cmd), .key_i(key), .col_i(col), .mask_i(mask),
    .col_o(col_o), .rd_valid_o(rd_valid_o), .wr_en_o(wr_en_o), .oe_o(oe_o)
  );

  int n_chk = 0, n_err = 0, e = 0;
  bit done = 0, pat_on = 0, counting = 0;
  int rdcnt = 0;
  string t_col = "R3", t_rd = "R6", t_wr = "R7", t_oe = "R8";

  // expectation model, indexed by edge number modulo 1024
  bit         mcolv[1024];
  logic [7:0] mcol[1024];
  bit         mrd[1024];
  bit         mwr[1024];
  logic [1:0] mmask[1024];

  // mode as the bench understands it
  int b_len = 1, b_lat = 2;
  bit b_full = 0, b_ilv = 0, b_sw = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [7:0] colcalc(input logic [7:0] s, input int i);
    int m;
    if (b_full) return 8'((int'(s) + i) & 255);
    if (b_ilv) return s ^ 8'(i);
    m = b_len - 1;
    return 8'((int'(s) & ~m) | ((int'(s) + i) & m));
  endfunction

  task automatic model_cmd(input logic [2:0] c, input logic [7:0] s,
                           input logic [11:0] k, input int en);
    int n;
    if (c >= C_MODE && c <= C_PRE) begin
      for (int j = 0; j < 700; j++) begin
        mcolv[(en + j) % 1024] = 0;
        mwr[(en + j) % 1024] = 0;
        mrd[(en + b_lat - 1 + j) % 1024] = 0;
      end
    end
    if (c == C_MODE) begin
      if (k[8:7] == 0 && k[11:10] == 0 && (k[2:0] <= 3 || (k[2:0] == 7 && !k[3]))
          && (k[6:4] == 2 || k[6:4] == 3)) begin
        b_full = (k[2:0] == 7);
        b_len  = b_full ? 256 : (1 << k[2:0]);
        b_ilv  = k[3];
        b_lat  = int'(k[6:4]);
        b_sw   = k[9];
      end
    end
    if (c == C_RD || c == C_WR) begin
      n = (c == C_WR && b_sw) ? 1 : (b_full ? 600 : b_len);
      for (int i = 0; i < n; i++) begin
        mcolv[(en + i) % 1024] = 1;
        mcol[(en + i) % 1024]  = (c == C_WR && b_sw) ? s : colcalc(s, i);
        if (c == C_WR) mwr[(en + i) % 1024] = 1;
        else           mrd[(en + i + b_lat - 1) % 1024] = 1;
      end
    end
  endtask

  task automatic check_edge(input int en);
    int i, ip;
    logic [1:0] ewr, eoe;
    i  = en % 1024;
    ip = (en + 1023) % 1024;
    ewr = mwr[i] ? ~mmask[i] : 2'b00;
    eoe = mrd[i] ? ~mmask[ip] : 2'b00;
    chk(t_rd, "rd_valid", int'(rd_valid_o), int'(mrd[i]));
    chk(t_wr, "wr_en", int'(wr_en_o), int'(ewr));
    chk(t_oe, "oe", int'(oe_o), int'(eoe));
    if (mcolv[i]) chk(t_col, "col", int'(col_o), int'(mcol[i]));
    if (counting) rdcnt += int'(rd_valid_o);
    mcolv[i] = 0; mrd[i] = 0; mwr[i] = 0;
  endtask

  task automatic drive(input logic [2:0] c, input logic [7:0] s, input logic [11:0] k);
    int en = e + 1;
    logic [1:0] m = pat_on ? 2'((en ^ (en >> 2)) & 3) : 2'b00;
    cmd = c; col = s; key = k; mask = m;
    mmask[en % 1024] = m;
    model_cmd(c, s, k, en);
    @(posedge clk);
    @(negedge clk);
    e = en;
    check_edge(en);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(C_NOP, 8'h00, 12'h000);
  endtask

  function automatic logic [11:0] mkey(input int bl, input int ilv, input int lat, input int sw);
    return 12'((sw << 9) | (lat << 4) | (ilv << 3) | bl);
  endfunction

  task automatic interrupt_read(input int lat, input logic [2:0] kill);
    drive(C_MODE, 8'h00, mkey(3, 0, lat, 0));
    idle(1);
    drive(C_RD, 8'h20, 12'h000);
    idle(2);
    rdcnt = 0; counting = 1;
    drive(kill, 8'h00, 12'h000);
    idle(7);
    counting = 0;
    chk("R9", "valid words after interrupt", rdcnt, lat - 1);
  endtask

  initial begin
    rst = 1; cmd = C_NOP; key = '0; col = '0; mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "col in reset", int'(col_o), 0);
    chk("R1", "rd_valid in reset", int'(rd_valid_o), 0);
    chk("R1", "wr_en in reset", int'(wr_en_o), 0);
    chk("R1", "oe in reset", int'(oe_o), 0);
    rst = 0;

    // R1: default mode gives single beats at latency 2
    t_col = "R1"; t_rd = "R1"; t_wr = "R1"; t_oe = "R1";
    idle(2);
    drive(C_RD, 8'h35, 12'h000); idle(4);
    drive(C_WR, 8'h36, 12'h000); idle(3);

    // R3 R4 R6 R7 R8: sweep of lengths, orders, latencies and start columns
    pat_on = 1;
    t_rd = "R6"; t_wr = "R7"; t_oe = "R8";
    for (int lat = 2; lat <= 3; lat++)
      for (int ilv = 0; ilv <= 1; ilv++)
        for (int bl = 0; bl <= 3; bl++) begin
          t_col = ilv ? "R4" : "R3";
          drive(C_MODE, 8'h00, mkey(bl, ilv, lat, 0));
          idle(1);
          for (int si = 0; si < 3; si++) begin
            logic [7:0] s = (si == 0) ? 8'h00 : (si == 1) ? 8'h5B : 8'hF7;
            drive(C_RD, s, 12'h000); idle((1 << bl) + lat + 1);
            drive(C_WR, s + 8'h1, 12'h000); idle((1 << bl) + 1);
          end
        end

    // R2: illegal keys leave a length-4 sequential latency-2 mode in place
    t_col = "R2"; t_rd = "R2";
    drive(C_MODE, 8'h00, mkey(2, 0, 2, 0)); idle(1);
    drive(C_MODE, 8'h00, mkey(4, 0, 3, 0));
    drive(C_MODE, 8'h00, mkey(7, 1, 3, 0));
    drive(C_MODE, 8'h00, mkey(1, 0, 1, 0));
    drive(C_MODE, 8'h00, mkey(1, 0, 4, 0));
    drive(C_MODE, 8'h00, mkey(1, 0, 3, 0) | 12'h800);
    drive(C_MODE, 8'h00, mkey(1, 0, 3, 0) | 12'h080);
    idle(1);
    drive(C_RD, 8'h0E, 12'h000); idle(7);
    drive(C_MODE, 8'h00, mkey(1, 1, 3, 0)); idle(1);
    drive(C_RD, 8'h0F, 12'h000); idle(6);

    // R5: full-page read crossing column 255, then full-page write
    t_col = "R5"; t_rd = "R5"; t_wr = "R5";
    drive(C_MODE, 8'h00, mkey(7, 0, 3, 0)); idle(1);
    drive(C_RD, 8'hF0, 12'h000); idle(300);
    drive(C_STOP, 8'h00, 12'h000); idle(5);
    drive(C_WR, 8'h05, 12'h000); idle(270);
    drive(C_PRE, 8'h00, 12'h000); idle(4);

    // R9: interrupted reads keep L-1 words in flight
    pat_on = 0;
    t_col = "R9"; t_rd = "R9"; t_wr = "R9"; t_oe = "R9";
    interrupt_read(2, C_STOP);
    interrupt_read(3, C_PRE);
    interrupt_read(2, C_PRE);
    interrupt_read(3, C_STOP);

    // R10: interrupted writes stop writing at once
    t_col = "R10"; t_rd = "R10"; t_wr = "R10"; t_oe = "R10";
    drive(C_MODE, 8'h00, mkey(3, 0, 2, 0)); idle(1);
    drive(C_WR, 8'h48, 12'h000); idle(2);
    drive(C_PRE, 8'h00, 12'h000); idle(6);
    drive(C_WR, 8'h4C, 12'h000); idle(1);
    drive(C_STOP, 8'h00, 12'h000); idle(6);

    // R11: single-write mode
    t_col = "R11"; t_rd = "R11"; t_wr = "R11"; t_oe = "R11";
    drive(C_MODE, 8'h00, mkey(2, 0, 3, 1)); idle(1);
    drive(C_WR, 8'h11, 12'h000); idle(6);
    drive(C_RD, 8'h11, 12'h000); idle(8);

    // R12: restart mid-burst with a new read and with a write
    t_col = "R12"; t_rd = "R12"; t_wr = "R12"; t_oe = "R12";
    drive(C_MODE, 8'h00, mkey(3, 0, 2, 0)); idle(1);
    drive(C_RD, 8'h40, 12'h000); idle(2);
    drive(C_RD, 8'h83, 12'h000); idle(3);
    drive(C_WR, 8'hC6, 12'h000); idle(10);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      finish_run();
    end
  end
endmodule